// File: doc/BRIEF.md
# Four-Channel Digital Potentiometer Instruction Executor

This block is the execution core behind a serial-bus digital potentiometer controller. It holds the register state of four potentiometer channels, each with one volatile 6-bit wiper register and four 6-bit data registers. The data registers stand in for nonvolatile cells and are built from flops. A bus front end, which is not part of this block, hands over decoded bytes as single-cycle strobes: an instruction strobe carrying the instruction byte, a data strobe carrying a payload byte, and a step strobe carrying a direction bit.

The core decodes each instruction byte into an opcode, a data-register select and a channel select. It then performs one of these operations: a read, a direct write, a transfer between a data register and a wiper (for one channel or for all four), or step mode on one wiper. Any operation that changes a data register opens a busy window of a set number of clocks. This window models the slow nonvolatile write, and every strobe is ignored while it lasts. A low write-protect pin blocks data-register writes outright. On the first clock after reset, each channel's data register 0 is copied into its wiper.

Top module: `digipot_top`

## Requirements
- R1: On the first clock after reset is released, each channel's wiper takes the value of that channel's data register 0. Data register s of channel c resets to (DR_SEED + 4*c + s) mod 64, and the wipers are 0 before this recall.
- R2: The instruction byte decodes as follows: bits [7:4] are the opcode, bits [3:2] select the data register, and bits [1:0] select the channel.
- R3: Opcode 1001 reads the selected wiper and opcode 1011 reads the selected data register. The clock edge that samples the instruction strobe drives rdValid high for exactly one cycle, with the value on rdData.
- R4: Opcode 1010 arms a wiper write. The next accepted data strobe loads dataByte[5:0] into that channel's wiper, and dataByte[7:6] are ignored.
- R5: Opcode 1100 arms a data-register write. The next accepted data strobe stores dataByte[5:0] into the selected register and starts the busy window.
- R6: Opcode 1101 copies the selected data register into its own channel's wiper. Opcode 0001 does the same for all four channels at once, and in that case the channel bits have no effect.
- R7: Opcode 1110 stores the selected channel's wiper into its selected data register. Opcode 1000 stores every wiper into that channel's selected data register. Both start the busy window.
- R8: Opcode 0010 enables step mode on the selected wiper. Each later step strobe raises the wiper by 1 when stepUp=1 and lowers it by 1 when stepUp=0, holding at 63 and at 0. Step mode stays active until the next listed instruction.
- R9: Busy is high for exactly NV_CYCLES clocks, starting on the clock edge that commits a data-register change. While busy is high, every strobe is ignored.
- R10: While wpN is low, data-register writes and stores change nothing and do not assert busy.
- R11: An instruction with an unlisted opcode changes no register, and any armed write or step mode stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wpN | input | 1 | Write-protect, low blocks data-register writes |
| instrValid | input | 1 | Instruction byte strobe |
| instrByte | input | 8 | Instruction byte |
| dataValid | input | 1 | Payload byte strobe |
| dataByte | input | 8 | Payload byte, bits [5:0] used |
| stepValid | input | 1 | Step strobe in step mode |
| stepUp | input | 1 | Step direction, 1 raises the wiper |
| rdValid | output | 1 | Read result valid, one cycle |
| rdData | output | 6 | Read result |
| busy | output | 1 | Nonvolatile write window active |
| wiperBus | output | 24 | Wiper registers, channel c at bits [6c+5:6c] |

## Verification
The bench builds the block with NV_CYCLES=8 and DR_SEED=10. The short busy window lets stores follow one another closely, and lets the bench place instructions inside the window to show they are dropped. The seed gives every data register a distinct reset value, so recall, single and global transfers, and stores that land in the wrong slot all produce visibly wrong values.

// File: rtl/digipot_pkg.sv
package digipot_pkg;
  localparam int NUM_CH  = 4;
  localparam int NUM_DR  = 4;
  localparam int VAL_W   = 6;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int SEL_W   = $clog2(NUM_DR);
  localparam int BYTE_W  = 8;

  typedef enum logic [3:0] {
    OP_GLB_LOAD  = 4'b0001,
    OP_STEP      = 4'b0010,
    OP_GLB_STORE = 4'b1000,
    OP_RD_WIPER  = 4'b1001,
    OP_WR_WIPER  = 4'b1010,
    OP_RD_DR     = 4'b1011,
    OP_WR_DR     = 4'b1100,
    OP_LOAD      = 4'b1101,
    OP_STORE     = 4'b1110
  } opcode_e;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_WIPER,
    PEND_DR,
    PEND_STEP
  } pend_e;

  typedef struct packed {
    logic             recall;
    logic             wrWiper;
    logic             wrDr;
    logic             loadDr;
    logic             storeDr;
    logic             allCh;
    logic             stepMove;
    logic             stepUp;
    logic             rdWiper;
    logic             rdDr;
    logic [CH_W-1:0]  ch;
    logic [SEL_W-1:0] sel;
    logic [VAL_W-1:0] value;
  } dp_strobe_t;
endpackage

// File: rtl/digipot_ctrl.sv
module digipot_ctrl
  import digipot_pkg::*;
#(
  parameter int NV_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  logic              instrValid,
  input  logic [BYTE_W-1:0] instrByte,
  input  logic              dataValid,
  input  logic [BYTE_W-1:0] dataByte,
  input  logic              stepValid,
  input  logic              stepUp,
  output dp_strobe_t        strobe,
  output logic              busy
);
  localparam int CNT_W = $clog2(NV_CYCLES + 1);

  logic             recallPend;
  pend_e            pend, nextPend;
  logic [CH_W-1:0]  pendCh;
  logic [SEL_W-1:0] pendSel;
  logic [CNT_W-1:0] busyCnt;
  logic             startNv;
  logic             capturePtr;
  logic             unusedHighBits;

  assign unusedHighBits = ^dataByte[BYTE_W-1:VAL_W];
  assign busy = (busyCnt != '0);

  always_comb begin
    strobe     = '0;
    nextPend   = pend;
    startNv    = 1'b0;
    capturePtr = 1'b0;
    strobe.ch    = instrByte[CH_W-1:0];
    strobe.sel   = instrByte[CH_W +: SEL_W];
    strobe.value = dataByte[VAL_W-1:0];
    if (recallPend) begin
      strobe.recall = 1'b1;
    end else if (!busy) begin
      if (instrValid) begin
        case (opcode_e'(instrByte[BYTE_W-1:BYTE_W-4]))
          OP_RD_WIPER: begin
            strobe.rdWiper = 1'b1;
            nextPend = PEND_NONE;
          end
          OP_RD_DR: begin
            strobe.rdDr = 1'b1;
            nextPend = PEND_NONE;
          end
          OP_WR_WIPER: begin
            nextPend = PEND_WIPER;
            capturePtr = 1'b1;
          end
          OP_WR_DR: begin
            nextPend = PEND_DR;
            capturePtr = 1'b1;
          end
          OP_STEP: begin
            nextPend = PEND_STEP;
            capturePtr = 1'b1;
          end
          OP_LOAD: begin
            strobe.loadDr = 1'b1;
            nextPend = PEND_NONE;
          end
          OP_GLB_LOAD: begin
            strobe.loadDr = 1'b1;
            strobe.allCh  = 1'b1;
            nextPend = PEND_NONE;
          end
          OP_STORE: begin
            strobe.storeDr = wpN;
            startNv  = wpN;
            nextPend = PEND_NONE;
          end
          OP_GLB_STORE: begin
            strobe.storeDr = wpN;
            strobe.allCh   = 1'b1;
            startNv  = wpN;
            nextPend = PEND_NONE;
          end
          default: ;
        endcase
      end else if (dataValid && pend == PEND_WIPER) begin
        strobe.wrWiper = 1'b1;
        strobe.ch      = pendCh;
        nextPend       = PEND_NONE;
      end else if (dataValid && pend == PEND_DR) begin
        strobe.wrDr = wpN;
        strobe.ch   = pendCh;
        strobe.sel  = pendSel;
        startNv     = wpN;
        nextPend    = PEND_NONE;
      end else if (stepValid && pend == PEND_STEP) begin
        strobe.stepMove = 1'b1;
        strobe.stepUp   = stepUp;
        strobe.ch       = pendCh;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recallPend <= 1'b1;
      pend       <= PEND_NONE;
      pendCh     <= '0;
      pendSel    <= '0;
      busyCnt    <= '0;
    end else begin
      recallPend <= 1'b0;
      pend       <= nextPend;
      if (capturePtr) begin
        pendCh  <= instrByte[CH_W-1:0];
        pendSel <= instrByte[CH_W +: SEL_W];
      end
      if (startNv) begin
        busyCnt <= CNT_W'(NV_CYCLES);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/digipot_regs.sv
module digipot_regs
  import digipot_pkg::*;
#(
  parameter int DR_SEED = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dp_strobe_t              strobe,
  output logic [NUM_CH*VAL_W-1:0] wiperBus,
  output logic                    rdValid,
  output logic [VAL_W-1:0]        rdData
);
  localparam logic [VAL_W-1:0] WIPER_MAX = {VAL_W{1'b1}};

  logic [NUM_CH*NUM_DR*VAL_W-1:0] drFlat;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [VAL_W-1:0] wiperQ;
    logic [VAL_W-1:0] drQ [NUM_DR];
    logic             hit;

    assign hit = strobe.allCh || (strobe.ch == CH_W'(c));
    assign wiperBus[c*VAL_W +: VAL_W] = wiperQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wiperQ <= '0;
      end else if (strobe.recall) begin
        wiperQ <= drQ[0];
      end else if (strobe.wrWiper && hit) begin
        wiperQ <= strobe.value;
      end else if (strobe.loadDr && hit) begin
        wiperQ <= drQ[strobe.sel];
      end else if (strobe.stepMove && hit) begin
        if (strobe.stepUp && wiperQ != WIPER_MAX) begin
          wiperQ <= wiperQ + 1'b1;
        end else if (!strobe.stepUp && wiperQ != '0) begin
          wiperQ <= wiperQ - 1'b1;
        end
      end
    end

    for (genvar s = 0; s < NUM_DR; s++) begin : g_dr
      logic slotHit;
      assign slotHit = hit && (strobe.sel == SEL_W'(s));
      assign drFlat[(c*NUM_DR + s)*VAL_W +: VAL_W] = drQ[s];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          drQ[s] <= VAL_W'(DR_SEED + c*NUM_DR + s);
        end else if (strobe.wrDr && slotHit) begin
          drQ[s] <= strobe.value;
        end else if (strobe.storeDr && slotHit) begin
          drQ[s] <= wiperQ;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdWiper || strobe.rdDr;
      if (strobe.rdWiper) begin
        rdData <= wiperBus[int'(strobe.ch)*VAL_W +: VAL_W];
      end else if (strobe.rdDr) begin
        rdData <= drFlat[(int'(strobe.ch)*NUM_DR + int'(strobe.sel))*VAL_W +: VAL_W];
      end
    end
  end
endmodule

// File: rtl/digipot_top.sv
module digipot_top
  import digipot_pkg::*;
#(
  parameter int NV_CYCLES = 500000,
  parameter int DR_SEED   = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wpN,
  input  logic                    instrValid,
  input  logic [BYTE_W-1:0]       instrByte,
  input  logic                    dataValid,
  input  logic [BYTE_W-1:0]       dataByte,
  input  logic                    stepValid,
  input  logic                    stepUp,
  output logic                    rdValid,
  output logic [VAL_W-1:0]        rdData,
  output logic                    busy,
  output logic [NUM_CH*VAL_W-1:0] wiperBus
);
  dp_strobe_t strobe;

  digipot_ctrl #(.NV_CYCLES(NV_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wpN        (wpN),
    .instrValid (instrValid),
    .instrByte  (instrByte),
    .dataValid  (dataValid),
    .dataByte   (dataByte),
    .stepValid  (stepValid),
    .stepUp     (stepUp),
    .strobe     (strobe),
    .busy       (busy)
  );

  digipot_regs #(.DR_SEED(DR_SEED)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wiperBus (wiperBus),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );
endmodule

// File: rtl/digipot_checker.sv
module digipot_checker
  import digipot_pkg::*;
#(
  parameter int NV_CYCLES = 500000
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wpN,
  input logic                    instrValid,
  input logic                    busy,
  input logic                    rdValid,
  input logic [NUM_CH*VAL_W-1:0] wiperBus
);
  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyRun <= 0;
    end else if (busy) begin
      busyRun <= busyRun + 1;
    end else begin
      busyRun <= 0;
    end
  end

  AST_BUSY_FREEZES_WIPERS: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(wiperBus)); // R9

  AST_BUSY_WINDOW_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && !busy) |-> (busyRun == NV_CYCLES)); // R9

  AST_BUSY_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < NV_CYCLES)); // R9

  AST_PROTECT_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!wpN && !busy) |=> !busy); // R10

  AST_READ_FOLLOWS_INSTR: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(instrValid) && !$past(busy))); // R3
endmodule

bind digipot_top digipot_checker #(.NV_CYCLES(NV_CYCLES)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .wpN        (wpN),
  .instrValid (instrValid),
  .busy       (busy),
  .rdValid    (rdValid),
  .wiperBus   (wiperBus)
);

// File: tb/tb_digipot_top.sv
module tb_digipot_top;
  localparam int NV   = 8;
  localparam int SEED = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wpN = 1'b1;
  logic       instrValid = 1'b0;
  logic [7:0] instrByte = '0;
  logic       dataValid = 1'b0;
  logic [7:0] dataByte = '0;
  logic       stepValid = 1'b0;
  logic       stepUp = 1'b0;
  logic       rdValid;
  logic [5:0] rdData;
  logic       busy;
  logic [23:0] wiperBus;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  int mWiper[4];
  int mDr[4][4];
  int mBusy, mPend, mPendCh, mPendSel, mRdValid, mRdData;
  bit mRecall;

  digipot_top #(.NV_CYCLES(NV), .DR_SEED(SEED)) dut (
    .clk(clk), .rstN(rstN), .wpN(wpN),
    .instrValid(instrValid), .instrByte(instrByte),
    .dataValid(dataValid), .dataByte(dataByte),
    .stepValid(stepValid), .stepUp(stepUp),
    .rdValid(rdValid), .rdData(rdData), .busy(busy), .wiperBus(wiperBus)
  );

  always #5 clk = ~clk;

  function automatic int wOut(int c);
    return int'(wiperBus[c*6 +: 6]);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin
        mWiper[c] = 0;
        for (int s = 0; s < 4; s++) mDr[c][s] = (SEED + 4*c + s) % 64;
      end
      mBusy = 0; mPend = 0; mPendCh = 0; mPendSel = 0;
      mRdValid = 0; mRdData = 0; mRecall = 1;
    end else begin
      mRdValid = 0;
      if (mRecall) begin
        for (int c = 0; c < 4; c++) mWiper[c] = mDr[c][0];
        mRecall = 0;
      end else begin
        bit acc;
        int op, s, c;
        acc = (mBusy == 0);
        if (mBusy > 0) mBusy--;
        op = instrByte[7:4]; s = instrByte[3:2]; c = instrByte[1:0];
        if (acc) begin
          if (instrValid) begin
            case (op)
              9:  begin mRdValid = 1; mRdData = mWiper[c]; mPend = 0; end
              11: begin mRdValid = 1; mRdData = mDr[c][s]; mPend = 0; end
              10: begin mPend = 1; mPendCh = c; mPendSel = s; end
              12: begin mPend = 2; mPendCh = c; mPendSel = s; end
              2:  begin mPend = 3; mPendCh = c; mPendSel = s; end
              13: begin mWiper[c] = mDr[c][s]; mPend = 0; end
              1:  begin for (int k = 0; k < 4; k++) mWiper[k] = mDr[k][s]; mPend = 0; end
              14: begin if (wpN) begin mDr[c][s] = mWiper[c]; mBusy = NV; end mPend = 0; end
              8:  begin
                    if (wpN) begin
                      for (int k = 0; k < 4; k++) mDr[k][s] = mWiper[k];
                      mBusy = NV;
                    end
                    mPend = 0;
                  end
              default: ;
            endcase
          end else if (dataValid && mPend == 1) begin
            mWiper[mPendCh] = dataByte[5:0]; mPend = 0;
          end else if (dataValid && mPend == 2) begin
            if (wpN) begin mDr[mPendCh][mPendSel] = dataByte[5:0]; mBusy = NV; end
            mPend = 0;
          end else if (stepValid && mPend == 3) begin
            if (stepUp && mWiper[mPendCh] < 63) mWiper[mPendCh]++;
            else if (!stepUp && mWiper[mPendCh] > 0) mWiper[mPendCh]--;
          end
        end
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk("R9 busy vs model", int'(busy), (mBusy != 0) ? 1 : 0);
      chk("R3 rdValid vs model", int'(rdValid), mRdValid);
      chk("R3 rdData vs model", int'(rdData), mRdData);
      for (int c = 0; c < 4; c++) chk("R2 wiper vs model", wOut(c), mWiper[c]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic instr(int op, int s, int c);
    @(negedge clk);
    instrValid = 1'b1; instrByte = 8'((op << 4) | (s << 2) | c);
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  task automatic data(int b);
    @(negedge clk);
    dataValid = 1'b1; dataByte = 8'(b);
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic step(bit up);
    @(negedge clk);
    stepValid = 1'b1; stepUp = up;
    @(negedge clk);
    stepValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset wiper zero", wOut(1), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1: recall of data register 0
    chk("R1 recall ch0", wOut(0), 10);
    chk("R1 recall ch1", wOut(1), 14);
    chk("R1 recall ch2", wOut(2), 18);
    chk("R1 recall ch3", wOut(3), 22);

    // R3 reads
    instr(4'b1001, 0, 2);
    chk("R3 read wiper valid", int'(rdValid), 1);
    chk("R3 read wiper data", int'(rdData), 18);
    instr(4'b1011, 3, 1);
    chk("R3 R2 read data reg", int'(rdData), 17);

    // R4 direct wiper write, upper bits ignored
    instr(4'b1010, 0, 1);
    data(8'hC5);
    chk("R4 wiper write", wOut(1), 5);

    // R5 data register write with busy
    instr(4'b1100, 2, 3);
    data(8'h2A);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R9 busy length", n, NV);
    instr(4'b1011, 2, 3);
    chk("R5 data reg written", int'(rdData), 42);

    // R7 single store, then R9 ignored load while busy
    instr(4'b1110, 1, 0);
    chk("R7 store busy", int'(busy), 1);
    instr(4'b1101, 0, 1);
    chk("R9 load ignored while busy", wOut(1), 5);
    waitIdle();
    chk("R9 wiper kept after busy", wOut(1), 5);
    instr(4'b1011, 1, 0);
    chk("R7 single store", int'(rdData), 10);

    // R6 transfers
    instr(4'b1101, 2, 3);
    chk("R6 single load", wOut(3), 42);
    instr(4'b0001, 0, 3);
    chk("R6 global load ch1", wOut(1), 14);
    chk("R6 global load ch3", wOut(3), 22);

    // R7 global store
    instr(4'b1010, 0, 2);
    data(33);
    instr(4'b1000, 3, 0);
    chk("R7 global store busy", int'(busy), 1);
    waitIdle();
    instr(4'b1011, 3, 2);
    chk("R7 global store ch2", int'(rdData), 33);
    instr(4'b1011, 3, 1);
    chk("R7 global store ch1", int'(rdData), 14);

    // R10 write protect
    wpN = 1'b0;
    instr(4'b1100, 0, 0);
    data(8'h3F);
    chk("R10 protected write no busy", int'(busy), 0);
    instr(4'b1110, 0, 2);
    chk("R10 protected store no busy", int'(busy), 0);
    instr(4'b1011, 0, 0);
    chk("R10 register unchanged", int'(rdData), 10);
    instr(4'b1011, 0, 2);
    chk("R10 store unchanged", int'(rdData), 18);
    wpN = 1'b1;

    // R8 stepping and saturation
    instr(4'b0010, 0, 1);
    step(1); step(1); step(1);
    chk("R8 step up", wOut(1), 17);
    step(0); step(0);
    chk("R8 step down", wOut(1), 15);
    instr(4'b1010, 0, 1);
    data(62);
    instr(4'b0010, 0, 1);
    step(1); step(1); step(1);
    chk("R8 saturate high", wOut(1), 63);
    instr(4'b1010, 0, 0);
    data(1);
    instr(4'b0010, 0, 0);
    step(0); step(0); step(0);
    chk("R8 saturate low", wOut(0), 0);

    // R11 unlisted opcodes
    instr(4'b0010, 0, 2);
    instr(4'b0100, 0, 2);
    chk("R11 no change", wOut(2), 33);
    step(1);
    chk("R11 step kept armed", wOut(2), 34);
    instr(4'b1010, 0, 3);
    instr(4'b1111, 3, 3);
    data(7);
    chk("R11 write kept armed", wOut(3), 7);
    chk("R11 no busy", int'(busy), 0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule